// File: doc/BRIEF.md
# Length-Coded Instruction Address Sequencer

This block holds the instruction address field, the last-instruction length code and the condition code of a processor status word. Each time the fetch side reports a completed fetch, it moves the 24-bit byte address forward by 2, 4 or 6 bytes. The step size comes from a 2-bit length code. That code is also kept in a register so that interruption logic can report how long the last instruction was.

A branch request carries a 4-bit mask and a target. The block tests the stored condition code against the mask. When the test selects a 1, the target replaces the sequential address. A separate port writes a new condition code. A swap port replaces address, length code and condition code in one cycle; this is the path used when a whole status word is exchanged. Two pulse outputs flag a reserved length code and an odd branch target. In both of those cases the address is held.

Top module: `insn_addr_seq`

## Requirements
- R1: When `rst_n` is low at a clock edge, the address, length code and condition code become 0, and both error outputs become 0.
- R2: With `step_valid` high and `step_len` equal to 00, 01 or 10, the address grows by 2, 4 or 6 bytes and `last_len` takes the value of `step_len`. Both changes appear after that clock edge.
- R3: Address arithmetic wraps modulo 2^24. For example, 0xFFFFFC stepped by 6 bytes gives 0x000002.
- R4: A `step_valid` with `step_len` equal to 11 sets `len_fault` for exactly one cycle. In that case the address and `last_len` keep their values, and a branch request in the same cycle is ignored.
- R5: A branch is taken when `br_mask[3 - cc]` is 1, so mask bit 3 selects code 0 and mask bit 0 selects code 3. A taken branch loads `br_target`. A branch that is not taken leaves the sequential result: the stepped address when `step_valid` is high, otherwise the held address.
- R6: The branch test uses the condition code held before the edge. A `cc_wr` in the same cycle affects only later branches.
- R7: `cc_wr` loads `cc_in` into `cond_code`, which is visible after the edge.
- R8: A taken branch whose target has bit 0 set raises `tgt_fault` for one cycle. The address keeps its value and is not stepped. `last_len` is still recorded from a valid step in that cycle.
- R9: `swap_ld` overrides all other inputs in its cycle. It loads the address with bit 0 cleared, and it loads `swap_len` and `swap_cc`. Neither error output is raised.
- R10: Bit 0 of `insn_addr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | One instruction fetched; advance the address |
| step_len | input | 2 | Length code of that instruction |
| br_req | input | 1 | Conditional branch request |
| br_mask | input | 4 | Condition mask; bit 3 selects code 0 |
| br_target | input | 24 | Branch target byte address |
| cc_wr | input | 1 | Condition-code write strobe |
| cc_in | input | 2 | New condition code |
| swap_ld | input | 1 | Load the whole field from the swap unit |
| swap_addr | input | 24 | Swap address |
| swap_len | input | 2 | Swap length code |
| swap_cc | input | 2 | Swap condition code |
| insn_addr | output | 24 | Next instruction byte address |
| last_len | output | 2 | Length code of the last instruction |
| cond_code | output | 2 | Current condition code |
| len_fault | output | 1 | One-cycle pulse: reserved length code |
| tgt_fault | output | 1 | One-cycle pulse: odd taken-branch target |

## Verification
A condition-code write and a branch test can fall in the same cycle. The bench sets the code to 2, then in one cycle writes code 0 and requests a branch whose mask selects only code 0. The branch must not be taken, because it must see the old code; the new code must still appear on `cond_code`. The same branch is then repeated and must now be taken. This also gives each step-plus-branch overlap its own check: taken, not taken, reserved length and odd target.

// File: rtl/ias_pkg.sv
// Shared definitions for the instruction address sequencer.
// Assumes a 2-bit length code counted in halfwords.
package ias_pkg;
    localparam int ADDR_W = 24;
    localparam int LEN_W  = 2;
    localparam int CC_W   = 2;

    typedef enum logic [LEN_W-1:0] {
        LEN_HALF2 = 2'b00,
        LEN_HALF4 = 2'b01,
        LEN_HALF6 = 2'b10,
        LEN_RSVD  = 2'b11
    } len_code_e;
endpackage

// File: rtl/ias_len_decode.sv
// Turns a length code into a byte increment and a validity flag.
// Assumes that code k means (k+1) halfwords and that the all-ones code is reserved.
module ias_len_decode #(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 2
) (
    input  logic [LEN_W-1:0]  len_code,
    output logic [ADDR_W-1:0] byte_incr,
    output logic              code_ok
);
    import ias_pkg::*;

    // Work out the byte count and flag the reserved code.
    always_comb begin
        byte_incr = ADDR_W'({len_code, 1'b0}) + ADDR_W'(2);
        code_ok   = (len_code != LEN_W'(LEN_RSVD));
    end
endmodule

// File: rtl/ias_cond_test.sv
// Tests the condition code against a branch mask.
// Assumes the mask's most significant bit belongs to code 0.
module ias_cond_test #(
    parameter int CC_W = 2
) (
    input  logic [CC_W-1:0]      cc,
    input  logic [(1<<CC_W)-1:0] mask,
    output logic                 taken
);
    localparam int MASK_W = 1 << CC_W;

    logic [MASK_W-1:0] rev_mask;

    // Reverse the mask so that the condition code can index it directly.
    for (genvar i = 0; i < MASK_W; i++) begin : g_rev
        assign rev_mask[i] = mask[MASK_W-1-i];
    end

    // Pick the mask bit that the current code selects.
    always_comb taken = rev_mask[cc];
endmodule

// File: rtl/ias_next_addr.sv
// Picks the next instruction address. Order of precedence:
// swap load, then reserved length, then a taken branch, then the sequential step.
// Assumes the increment and the branch decision are valid in the same cycle.
module ias_next_addr #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              step_valid,
    input  logic              code_ok,
    input  logic [ADDR_W-1:0] byte_incr,
    input  logic              br_req,
    input  logic              br_taken,
    input  logic [ADDR_W-1:0] br_target,
    input  logic              swap_ld,
    input  logic [ADDR_W-1:0] swap_addr,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              set_len_fault,
    output logic              set_tgt_fault
);
    logic [ADDR_W-1:0] seq_addr;

    // Sequential address, wrapping modulo 2^ADDR_W.
    always_comb seq_addr = step_valid ? (cur_addr + byte_incr) : cur_addr;

    // Apply the precedence order to get the next address and the fault strobes.
    always_comb begin
        nxt_addr      = cur_addr;
        set_len_fault = 1'b0;
        set_tgt_fault = 1'b0;
        if (swap_ld) begin
            nxt_addr = swap_addr & ~ADDR_W'(1);
        end else if (step_valid && !code_ok) begin
            set_len_fault = 1'b1;
        end else if (br_req && br_taken) begin
            if (br_target[0]) set_tgt_fault = 1'b1;
            else              nxt_addr      = br_target;
        end else begin
            nxt_addr = seq_addr;
        end
    end
endmodule

// File: rtl/insn_addr_seq.sv
// Top of the sequencer: holds the address, last length code, condition code
// and the two fault pulses. Assumes at most one instruction step per cycle.
module insn_addr_seq #(
    parameter int ADDR_W = ias_pkg::ADDR_W,
    parameter int LEN_W  = ias_pkg::LEN_W,
    parameter int CC_W   = ias_pkg::CC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_valid,
    input  logic [LEN_W-1:0]     step_len,
    input  logic                 br_req,
    input  logic [(1<<CC_W)-1:0] br_mask,
    input  logic [ADDR_W-1:0]    br_target,
    input  logic                 cc_wr,
    input  logic [CC_W-1:0]      cc_in,
    input  logic                 swap_ld,
    input  logic [ADDR_W-1:0]    swap_addr,
    input  logic [LEN_W-1:0]     swap_len,
    input  logic [CC_W-1:0]      swap_cc,
    output logic [ADDR_W-1:0]    insn_addr,
    output logic [LEN_W-1:0]     last_len,
    output logic [CC_W-1:0]      cond_code,
    output logic                 len_fault,
    output logic                 tgt_fault
);
    logic [ADDR_W-1:0] byte_incr, nxt_addr;
    logic              code_ok, br_taken, set_len_fault, set_tgt_fault;

    ias_len_decode #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dec (
        .len_code (step_len),
        .byte_incr(byte_incr),
        .code_ok  (code_ok)
    );

    ias_cond_test #(.CC_W(CC_W)) u_cond (
        .cc   (cond_code),
        .mask (br_mask),
        .taken(br_taken)
    );

    ias_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
        .cur_addr     (insn_addr),
        .step_valid   (step_valid),
        .code_ok      (code_ok),
        .byte_incr    (byte_incr),
        .br_req       (br_req),
        .br_taken     (br_taken),
        .br_target    (br_target),
        .swap_ld      (swap_ld),
        .swap_addr    (swap_addr),
        .nxt_addr     (nxt_addr),
        .set_len_fault(set_len_fault),
        .set_tgt_fault(set_tgt_fault)
    );

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n) insn_addr <= '0;
        else        insn_addr <= nxt_addr;
    end

    // Last-length register: swap data, or a valid step's code.
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_len <= '0;
        else if (swap_ld)                last_len <= swap_len;
        else if (step_valid && code_ok)  last_len <= step_len;
    end

    // Condition-code register: swap data first, then an explicit write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cond_code <= '0;
        else if (swap_ld) cond_code <= swap_cc;
        else if (cc_wr)   cond_code <= cc_in;
    end

    // One-cycle fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_fault <= 1'b0;
            tgt_fault <= 1'b0;
        end else begin
            len_fault <= set_len_fault;
            tgt_fault <= set_tgt_fault;
        end
    end

    // R2 R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !br_req && !swap_ld && step_len != 2'b11)
        |=> insn_addr == $past(insn_addr) + ADDR_W'({$past(step_len), 1'b0}) + ADDR_W'(2));

    // R4
    rsvd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !swap_ld && step_len == 2'b11)
        |=> len_fault && $stable(insn_addr) && $stable(last_len));

    // R8
    tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_fault |-> $stable(insn_addr));

    // R9
    swap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_ld |=> !len_fault && !tgt_fault && cond_code == $past(swap_cc)
                    && last_len == $past(swap_len));

    // R10
    even_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_addr[0]);

    // R4 R8
    one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({len_fault, tgt_fault}));
endmodule

// File: tb/insn_addr_seq_test.sv
module insn_addr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_valid;
    logic [1:0]  step_len;
    logic        br_req;
    logic [3:0]  br_mask;
    logic [23:0] br_target;
    logic        cc_wr;
    logic [1:0]  cc_in;
    logic        swap_ld;
    logic [23:0] swap_addr;
    logic [1:0]  swap_len;
    logic [1:0]  swap_cc;
    logic [23:0] insn_addr;
    logic [1:0]  last_len;
    logic [1:0]  cond_code;
    logic        len_fault;
    logic        tgt_fault;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    insn_addr_seq uut (
        .clk(clk), .rst_n(rst_n),
        .step_valid(step_valid), .step_len(step_len),
        .br_req(br_req), .br_mask(br_mask), .br_target(br_target),
        .cc_wr(cc_wr), .cc_in(cc_in),
        .swap_ld(swap_ld), .swap_addr(swap_addr), .swap_len(swap_len), .swap_cc(swap_cc),
        .insn_addr(insn_addr), .last_len(last_len), .cond_code(cond_code),
        .len_fault(len_fault), .tgt_fault(tgt_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        step_valid = 0; step_len = 0; br_req = 0; br_mask = 0; br_target = 0;
        cc_wr = 0; cc_in = 0; swap_ld = 0; swap_addr = 0; swap_len = 0; swap_cc = 0;
    endtask

    // Apply the driven inputs for one edge, then leave time to settle before sampling.
    task automatic tick();
        @(posedge clk);
        #1;
        @(negedge clk);
    endtask

    task automatic swap_to(input logic [23:0] a, input logic [1:0] l, input logic [1:0] c);
        idle(); swap_ld = 1; swap_addr = a; swap_len = l; swap_cc = c;
        tick(); idle();
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        step_valid = 1; step_len = 2'b01;
        tick(); tick();
        rst_n = 1; idle();
        check("R1 addr", insn_addr, 0);
        check("R1 len", last_len, 0);
        check("R1 cc", cond_code, 0);
        check("R1 faults", {len_fault, tgt_fault}, 0);
    endtask

    task automatic t_advance();
        step_valid = 1; step_len = 2'b00; tick();
        check("R2 step2", insn_addr, 24'h2);
        check("R2 len00", last_len, 2'b00);
        step_len = 2'b01; tick();
        check("R2 step4", insn_addr, 24'h6);
        check("R2 len01", last_len, 2'b01);
        step_len = 2'b10; tick();
        check("R2 step6", insn_addr, 24'hC);
        check("R2 len10", last_len, 2'b10);
        idle(); tick();
        check("R2 idle hold", insn_addr, 24'hC);
    endtask

    task automatic t_wrap();
        swap_to(24'hFFFFFC, 2'b00, 2'b01);
        check("R9 swap addr", insn_addr, 24'hFFFFFC);
        step_valid = 1; step_len = 2'b10; tick(); idle();
        check("R3 wrap", insn_addr, 24'h000002);
    endtask

    task automatic t_reserved();
        swap_to(24'h000040, 2'b01, 2'b00);
        step_valid = 1; step_len = 2'b11; br_req = 1; br_mask = 4'hF; br_target = 24'h000100;
        tick(); idle();
        check("R4 addr held", insn_addr, 24'h000040);
        check("R4 len held", last_len, 2'b01);
        check("R4 fault", len_fault, 1);
        tick();
        check("R4 one cycle", len_fault, 0);
    endtask

    task automatic t_branch();
        swap_to(24'h000200, 2'b00, 2'b00);
        cc_wr = 1; cc_in = 2'b10; tick(); idle();
        check("R7 cc write", cond_code, 2'b10);
        step_valid = 1; step_len = 2'b01; br_req = 1; br_mask = 4'b0010; br_target = 24'h000400;
        tick(); idle();
        check("R5 taken", insn_addr, 24'h000400);
        step_valid = 1; step_len = 2'b00; br_req = 1; br_mask = 4'b1000; br_target = 24'h000800;
        tick(); idle();
        check("R5 not taken steps", insn_addr, 24'h000402);
        br_req = 1; br_mask = 4'b1101; br_target = 24'h000800;
        tick(); idle();
        check("R5 not taken holds", insn_addr, 24'h000402);
    endtask

    task automatic t_cc_overlap();
        cc_wr = 1; cc_in = 2'b00; br_req = 1; br_mask = 4'b1000; br_target = 24'h000800;
        tick(); idle();
        check("R6 old cc used", insn_addr, 24'h000402);
        check("R6 new cc stored", cond_code, 2'b00);
        br_req = 1; br_mask = 4'b1000; br_target = 24'h000800;
        tick(); idle();
        check("R6 later branch", insn_addr, 24'h000800);
    endtask

    task automatic t_odd_target();
        step_valid = 1; step_len = 2'b01; br_req = 1; br_mask = 4'hF; br_target = 24'h001001;
        tick(); idle();
        check("R8 addr held", insn_addr, 24'h000800);
        check("R8 fault", tgt_fault, 1);
        check("R8 len recorded", last_len, 2'b01);
        tick();
        check("R8 one cycle", tgt_fault, 0);
    endtask

    task automatic t_swap_override();
        swap_ld = 1; swap_addr = 24'h123457; swap_len = 2'b10; swap_cc = 2'b11;
        step_valid = 1; step_len = 2'b11; br_req = 1; br_mask = 4'hF; br_target = 24'h002001;
        cc_wr = 1; cc_in = 2'b01;
        tick(); idle();
        check("R9 R10 addr", insn_addr, 24'h123456);
        check("R9 len", last_len, 2'b10);
        check("R9 cc", cond_code, 2'b11);
        check("R9 no faults", {len_fault, tgt_fault}, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_advance();
        t_wrap();
        t_reserved();
        t_branch();
        t_cc_overlap();
        t_odd_target();
        t_swap_override();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule